// File: doc/BRIEF.md
# USB Host Attach and Reset Sequencer

This block drives device attach for a USB host controller whose registers sit behind a serial register port. It waits on the controller's active-low interrupt line. For each interrupt it reads the host interrupt flags, writes the same value back to clear them, and then acts on the flags according to its own attach state. A newly connected device has its line state examined so that low or full speed can be selected, and a bus reset is started. When the reset ends, start-of-frame keep-alive is enabled. On the first usable frame the block hands off to an enumeration engine and waits for it to finish. Keep-alive is then switched off again.

All register traffic goes out as single request/acknowledge accesses. A surrounding bridge turns each access into a serial transaction. The attach state is visible on an output so that later logic can tell when a device is ready.

Top module: `usb_attach_seq`

## Requirements
- R1: While reset is held, `devState` is 0, `regReq` is 0 and `enumStart` is 0. State codes are 0 idle/unattached, 1 attached, 2 in reset, 3 ready.
- R2: When `intN` is low and no sequence is running, the first access reads address 25. The second access writes address 25 with exactly the byte that was read.
- R3: The cleared flag byte is decoded as follows: bit0 is a bus event, bit3 is send buffer free, bit5 is attach/detach and bit6 is a frame start. Other bits are ignored.
- R4: In state 0, an attach flag causes a read of address 31 and then a read of address 27. Bit7 of the first byte is J and bit6 is K. If J and K are both set or both clear, no further access follows and the state stays 0.
- R5: Otherwise the device is low speed when (J and bit1 of the byte read from address 27) or (K and not that bit). Low speed writes 0xC3 to address 27; full speed writes 0xC1. Either write is followed by a write of 0x01 to address 29, and the state becomes 1.
- R6: In state 1, a bus event reads address 27, writes it back with bit3 set, and the state becomes 2.
- R7: In state 2, a frame flag together with a send-buffer flag raises `enumStart` for exactly one cycle. The state stays 2 until `enumDone`, then becomes 3. After that, address 27 is read and written back with bit3 cleared.
- R8: In state 2, a frame flag without the send-buffer flag changes nothing beyond the read and clear.
- R9: In any state other than 0, an attach flag returns the state to 0 unless a higher-priority action applies. The priority order is: attach in state 0, bus event in state 1, usable frame in state 2, then detach.
- R10: `regReq` stays high with address, write flag and write data stable until `regAck`. Only one access is in flight, and `intN` is not looked at again until the whole sequence for the current event has finished.
- R11: Flags that match no action in the current state produce only the read and the clear, and the state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| intN | input | 1 | Active-low interrupt from the host controller |
| regReq | output | 1 | Register access request |
| regWrite | output | 1 | 1 = write access, 0 = read access |
| regAddr | output | 5 | Register address |
| regWdata | output | 8 | Write data |
| regAck | input | 1 | Access accepted; read data valid in this cycle |
| regRdata | input | 8 | Read data |
| enumStart | output | 1 | One-cycle strobe that starts enumeration |
| enumDone | input | 1 | Enumeration finished |
| devState | output | 2 | Attach state (0..3) |

## Verification
The checks assume the register bridge obeys the handshake: it returns read data in the same cycle as `regAck`, and it asserts `regAck` only while `regReq` is high. They also assume that `enumDone` arrives only after `enumStart`. The bench meets these assumptions with a register model that acknowledges after a programmable delay (zero or three cycles) and records each access. The model releases `intN` only once the clear write to address 25 has completed. `enumDone` is pulsed once, after the strobe has been seen.

// File: rtl/usb_attach_pkg.sv
package usb_attach_pkg;

  typedef enum logic [1:0] {
    DEV_INIT  = 2'd0,
    DEV_CONN  = 2'd1,
    DEV_RESET = 2'd2,
    DEV_READY = 2'd3
  } devState_e;

  typedef enum logic [2:0] {
    WD_NONE,
    WD_FLAGS,
    WD_SPEED,
    WD_BUSRST,
    WD_KA_ON,
    WD_KA_OFF
  } wdSel_e;

  typedef struct packed {
    logic      capFlags;
    logic      capRsl;
    logic      capMode;
    logic      stLoad;
    devState_e stVal;
  } dpCtl_t;

  localparam int IRQ_ADDR  = 25;
  localparam int RSL_ADDR  = 31;
  localparam int MODE_ADDR = 27;
  localparam int HCTL_ADDR = 29;

  localparam int IRQ_BUS_BIT    = 0;
  localparam int IRQ_SNDBUF_BIT = 3;
  localparam int IRQ_CONN_BIT   = 5;
  localparam int IRQ_FRAME_BIT  = 6;

  localparam int RSL_J_BIT     = 7;
  localparam int RSL_K_BIT     = 6;
  localparam int MODE_LOW_BIT  = 1;
  localparam int MODE_KA_BIT   = 3;

  localparam int MODE_FULL_VAL = 8'hC1;
  localparam int MODE_LOW_VAL  = 8'hC3;
  localparam int BUSRST_VAL    = 8'h01;

endpackage

// File: rtl/usb_attach_dp.sv
module usb_attach_dp
  import usb_attach_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtl_t            ctl,
  input  wdSel_e            wdSel,
  input  logic [DATA_W-1:0] regRdata,
  output devState_e         devState,
  output logic [DATA_W-1:0] regWdata,
  output logic              evtConn,
  output logic              evtBus,
  output logic              evtFrameGo,
  output logic              lineOk,
  output logic              isLow
);

  logic [DATA_W-1:0] flagsQ, rslQ, modeQ;
  logic jBit, kBit, lowBit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flagsQ   <= '0;
      rslQ     <= '0;
      modeQ    <= '0;
      devState <= DEV_INIT;
    end else begin
      if (ctl.capFlags) flagsQ <= regRdata;
      if (ctl.capRsl)   rslQ   <= regRdata;
      if (ctl.capMode)  modeQ  <= regRdata;
      if (ctl.stLoad)   devState <= ctl.stVal;
    end
  end

  assign jBit   = rslQ[RSL_J_BIT];
  assign kBit   = rslQ[RSL_K_BIT];
  assign lowBit = modeQ[MODE_LOW_BIT];

  assign lineOk     = jBit ^ kBit;
  assign isLow      = (jBit & lowBit) | (kBit & ~lowBit);
  assign evtConn    = flagsQ[IRQ_CONN_BIT];
  assign evtBus     = flagsQ[IRQ_BUS_BIT];
  assign evtFrameGo = flagsQ[IRQ_FRAME_BIT] & flagsQ[IRQ_SNDBUF_BIT];

  always_comb begin
    regWdata = '0;
    case (wdSel)
      WD_FLAGS:  regWdata = flagsQ;
      WD_SPEED:  regWdata = isLow ? DATA_W'(MODE_LOW_VAL) : DATA_W'(MODE_FULL_VAL);
      WD_BUSRST: regWdata = DATA_W'(BUSRST_VAL);
      WD_KA_ON:  begin regWdata = modeQ; regWdata[MODE_KA_BIT] = 1'b1; end
      WD_KA_OFF: begin regWdata = modeQ; regWdata[MODE_KA_BIT] = 1'b0; end
      default:   regWdata = '0;
    endcase
  end

endmodule

// File: rtl/usb_attach_ctl.sv
module usb_attach_ctl
  import usb_attach_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              intN,
  input  logic              regAck,
  input  logic              enumDone,
  input  devState_e         devState,
  input  logic              evtConn,
  input  logic              evtBus,
  input  logic              evtFrameGo,
  input  logic              lineOk,
  output dpCtl_t            ctl,
  output wdSel_e            wdSel,
  output logic              regReq,
  output logic              regWrite,
  output logic [ADDR_W-1:0] regAddr,
  output logic              enumStart
);

  typedef enum logic [3:0] {
    PH_IDLE, PH_RD_IRQ, PH_WR_IRQ, PH_DECIDE,
    PH_RD_RSL, PH_RD_MODE, PH_SPEED, PH_WR_MODE, PH_WR_HCTL,
    PH_KA_RD, PH_KA_WR, PH_ENUM_GO, PH_ENUM_WAIT, PH_KC_RD, PH_KC_WR
  } phase_e;

  phase_e ph, phNext;

  always_ff @(posedge clk) begin
    if (!rst_n) ph <= PH_IDLE;
    else        ph <= phNext;
  end

  always_comb begin
    phNext    = ph;
    ctl       = '0;
    wdSel     = WD_NONE;
    regReq    = 1'b0;
    regWrite  = 1'b0;
    regAddr   = '0;
    enumStart = 1'b0;
    case (ph)
      PH_IDLE: if (!intN) phNext = PH_RD_IRQ;
      PH_RD_IRQ: begin
        regReq = 1'b1; regAddr = ADDR_W'(IRQ_ADDR);
        if (regAck) begin ctl.capFlags = 1'b1; phNext = PH_WR_IRQ; end
      end
      PH_WR_IRQ: begin
        regReq = 1'b1; regWrite = 1'b1; regAddr = ADDR_W'(IRQ_ADDR); wdSel = WD_FLAGS;
        if (regAck) phNext = PH_DECIDE;
      end
      PH_DECIDE: begin
        if (devState == DEV_INIT && evtConn)          phNext = PH_RD_RSL;
        else if (devState == DEV_CONN && evtBus)      phNext = PH_KA_RD;
        else if (devState == DEV_RESET && evtFrameGo) phNext = PH_ENUM_GO;
        else begin
          if (devState != DEV_INIT && evtConn) begin
            ctl.stLoad = 1'b1; ctl.stVal = DEV_INIT;
          end
          phNext = PH_IDLE;
        end
      end
      PH_RD_RSL: begin
        regReq = 1'b1; regAddr = ADDR_W'(RSL_ADDR);
        if (regAck) begin ctl.capRsl = 1'b1; phNext = PH_RD_MODE; end
      end
      PH_RD_MODE: begin
        regReq = 1'b1; regAddr = ADDR_W'(MODE_ADDR);
        if (regAck) begin ctl.capMode = 1'b1; phNext = PH_SPEED; end
      end
      PH_SPEED: phNext = lineOk ? PH_WR_MODE : PH_IDLE;
      PH_WR_MODE: begin
        regReq = 1'b1; regWrite = 1'b1; regAddr = ADDR_W'(MODE_ADDR); wdSel = WD_SPEED;
        if (regAck) phNext = PH_WR_HCTL;
      end
      PH_WR_HCTL: begin
        regReq = 1'b1; regWrite = 1'b1; regAddr = ADDR_W'(HCTL_ADDR); wdSel = WD_BUSRST;
        if (regAck) begin ctl.stLoad = 1'b1; ctl.stVal = DEV_CONN; phNext = PH_IDLE; end
      end
      PH_KA_RD: begin
        regReq = 1'b1; regAddr = ADDR_W'(MODE_ADDR);
        if (regAck) begin ctl.capMode = 1'b1; phNext = PH_KA_WR; end
      end
      PH_KA_WR: begin
        regReq = 1'b1; regWrite = 1'b1; regAddr = ADDR_W'(MODE_ADDR); wdSel = WD_KA_ON;
        if (regAck) begin ctl.stLoad = 1'b1; ctl.stVal = DEV_RESET; phNext = PH_IDLE; end
      end
      PH_ENUM_GO: begin
        enumStart = 1'b1;
        phNext    = PH_ENUM_WAIT;
      end
      PH_ENUM_WAIT: if (enumDone) begin
        ctl.stLoad = 1'b1; ctl.stVal = DEV_READY; phNext = PH_KC_RD;
      end
      PH_KC_RD: begin
        regReq = 1'b1; regAddr = ADDR_W'(MODE_ADDR);
        if (regAck) begin ctl.capMode = 1'b1; phNext = PH_KC_WR; end
      end
      PH_KC_WR: begin
        regReq = 1'b1; regWrite = 1'b1; regAddr = ADDR_W'(MODE_ADDR); wdSel = WD_KA_OFF;
        if (regAck) phNext = PH_IDLE;
      end
      default: phNext = PH_IDLE;
    endcase
  end

endmodule

// File: rtl/usb_attach_seq.sv
module usb_attach_seq
  import usb_attach_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              intN,
  output logic              regReq,
  output logic              regWrite,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  input  logic              regAck,
  input  logic [DATA_W-1:0] regRdata,
  output logic              enumStart,
  input  logic              enumDone,
  output logic [1:0]        devState
);

  dpCtl_t    ctl;
  wdSel_e    wdSel;
  devState_e stateQ;
  logic      evtConn, evtBus, evtFrameGo, lineOk, isLow;

  usb_attach_ctl #(.ADDR_W(ADDR_W)) ctl_i (
    .clk(clk), .rst_n(rst_n), .intN(intN), .regAck(regAck), .enumDone(enumDone),
    .devState(stateQ), .evtConn(evtConn), .evtBus(evtBus), .evtFrameGo(evtFrameGo),
    .lineOk(lineOk), .ctl(ctl), .wdSel(wdSel), .regReq(regReq), .regWrite(regWrite),
    .regAddr(regAddr), .enumStart(enumStart)
  );

  usb_attach_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .wdSel(wdSel), .regRdata(regRdata),
    .devState(stateQ), .regWdata(regWdata), .evtConn(evtConn), .evtBus(evtBus),
    .evtFrameGo(evtFrameGo), .lineOk(lineOk), .isLow(isLow)
  );

  assign devState = stateQ;

endmodule

// File: rtl/usb_attach_chk.sv
module usb_attach_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              regReq,
  input logic              regWrite,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              regAck,
  input logic              enumStart,
  input logic [1:0]        devState
);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regReq && !regAck |=> regReq && $stable(regAddr) && $stable(regWrite) && $stable(regWdata));

  // R7
  enum_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enumStart |=> !enumStart);

  // R7
  enum_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enumStart |-> devState == 2'd2);

  // R5
  init_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(devState) && $past(devState) == 2'd0 |-> devState == 2'd1);

  // R7
  ready_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(devState) && devState == 2'd3 |-> $past(devState) == 2'd2);

  // R6
  reset_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(devState) && devState == 2'd2 |-> $past(devState) == 2'd1);

endmodule

bind usb_attach_seq usb_attach_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/usb_attach_seq_tb.sv
module usb_attach_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       intN = 1'b1;
  logic       regReq, regWrite, enumStart;
  logic [4:0] regAddr;
  logic [7:0] regWdata;
  logic       regAck = 1'b0;
  logic [7:0] regRdata = 8'h00;
  logic       enumDone = 1'b0;
  logic [1:0] devState;

  int checks = 0;
  int errors = 0;

  logic [7:0] mem [0:31];
  int   logAddr [0:63];
  bit   logWr   [0:63];
  int   logData [0:63];
  int   logN = 0;
  int   lat = 0;
  int   reqDrop = 0;
  int   enumCnt = 0;

  always #4 clk = ~clk;

  usb_attach_seq dut_i (
    .clk(clk), .rst_n(rst_n), .intN(intN), .regReq(regReq), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regAck(regAck), .regRdata(regRdata),
    .enumStart(enumStart), .enumDone(enumDone), .devState(devState)
  );

  // register model: acknowledges after lat cycles, logs each access
  initial begin
    int a; bit w; int d;
    for (int i = 0; i < 32; i++) mem[i] = 8'h00;
    a = 0; w = 0; d = 0;
    forever begin
      @(negedge clk);
      if (regAck) begin
        if (logN < 64) begin
          logAddr[logN] = a; logWr[logN] = w; logData[logN] = d;
          logN++;
        end
        if (w) mem[a] = d[7:0];
        if (w && a == 25) intN = 1'b1;
        regAck = 1'b0;
      end else if (regReq && rst_n) begin
        a = int'(regAddr); w = regWrite; d = int'(regWdata);
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          if (!regReq || int'(regAddr) != a || regWrite != w || int'(regWdata) != d) reqDrop++;
        end
        regRdata = mem[a];
        regAck   = 1'b1;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (enumStart) enumCnt++;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expAcc(int i, int addr, bit wr, int data, string req);
    int act, exp;
    act = (i < logN) ? ((logAddr[i] << 12) | (int'(logWr[i]) << 8) | (wr ? logData[i] : 0)) : -1;
    exp = (addr << 12) | (int'(wr) << 8) | (wr ? data : 0);
    chk(act == exp, req, $sformatf("access %0d {addr,wr,data}", i), act, exp);
  endtask

  task automatic runEvent(logic [7:0] irq);
    logN = 0;
    mem[25] = irq;
    @(negedge clk);
    intN = 1'b0;
    repeat (100) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    chk(devState == 2'd0, "R1", "state in reset", devState, 0);
    chk(regReq == 1'b0, "R1", "req in reset", regReq, 0);
    chk(enumStart == 1'b0, "R1", "enumStart in reset", enumStart, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_noMatch();
    runEvent(8'h01);
    expAcc(0, 25, 0, 0, "R2");
    expAcc(1, 25, 1, 8'h01, "R2");
    chk(logN == 2, "R11", "access count", logN, 2);
    chk(devState == 2'd0, "R11", "state", devState, 0);
  endtask

  task automatic t_badLine(logic [7:0] rsl);
    mem[31] = rsl;
    runEvent(8'h20);
    expAcc(2, 31, 0, 0, "R4");
    expAcc(3, 27, 0, 0, "R4");
    chk(logN == 4, "R4", "access count", logN, 4);
    chk(devState == 2'd0, "R4", "state", devState, 0);
  endtask

  task automatic t_attach(logic [7:0] rsl, logic [7:0] mode, int expMode, string req);
    mem[31] = rsl;
    mem[27] = mode;
    runEvent(8'h20);
    expAcc(1, 25, 1, 8'h20, "R2");
    expAcc(4, 27, 1, expMode, req);
    expAcc(5, 29, 1, 8'h01, "R5");
    chk(logN == 6, "R5", "access count", logN, 6);
    chk(devState == 2'd1, "R5", "state", devState, 1);
  endtask

  task automatic t_detach(logic [1:0] fromState);
    runEvent(8'h20);
    chk(logN == 2, "R9", $sformatf("detach from %0d count", fromState), logN, 2);
    chk(devState == 2'd0, "R9", "state after detach", devState, 0);
  endtask

  initial begin
    t_reset();
    t_noMatch();
    t_badLine(8'hC0);
    t_badLine(8'h00);
    // R5: J set, low bit clear -> full
    t_attach(8'h80, 8'h00, 8'hC1, "R5");
    // R3 R11: frame+sndbuf in attached state matches nothing
    runEvent(8'h48);
    chk(logN == 2, "R3", "frame in state 1 count", logN, 2);
    chk(devState == 2'd1, "R11", "state kept 1", devState, 1);
    // R6 R9: bus and attach together, bus wins
    runEvent(8'h21);
    expAcc(2, 27, 0, 0, "R6");
    expAcc(3, 27, 1, 8'hC9, "R6");
    chk(devState == 2'd2, "R9", "priority bus over detach", devState, 2);
    // R8
    runEvent(8'h40);
    chk(logN == 2, "R8", "frame without sndbuf count", logN, 2);
    chk(devState == 2'd2, "R8", "state kept 2", devState, 2);
    // R7
    logN = 0; enumCnt = 0;
    mem[25] = 8'h48;
    @(negedge clk);
    intN = 1'b0;
    repeat (40) @(negedge clk);
    chk(enumCnt == 1, "R7", "enumStart pulses", enumCnt, 1);
    chk(devState == 2'd2, "R7", "state while enumerating", devState, 2);
    chk(logN == 2, "R7", "no access while enumerating", logN, 2);
    enumDone = 1'b1;
    @(negedge clk);
    enumDone = 1'b0;
    repeat (40) @(negedge clk);
    chk(devState == 2'd3, "R7", "state after done", devState, 3);
    expAcc(2, 27, 0, 0, "R7");
    expAcc(3, 27, 1, 8'hC1, "R7");
    chk(enumCnt == 1, "R7", "single enumStart", enumCnt, 1);
    t_detach(2'd3);
    // R5 R10: K with low bit clear -> low, slow bridge
    lat = 3;
    t_attach(8'h40, 8'hC1, 8'hC3, "R5");
    t_detach(2'd1);
    lat = 0;
    t_attach(8'h80, 8'hC3, 8'hC3, "R5");
    t_detach(2'd1);
    t_attach(8'h40, 8'hC3, 8'hC1, "R5");
    chk(reqDrop == 0, "R10", "request held stable until ack", reqDrop, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule